// File: doc/BRIEF.md
# Serial Cyclic Checkword Unit

This block computes a 12-bit cyclic checkword over a bit-serial disk record. Each record bit arrives on `bit_i`, qualified by `vld_i`, most significant bit first. The bit is folded into a remainder register that divides the record by the generator x^12 + x^11 + x^3 + x^2 + x + 1. The same unit serves the 24-bit address field and the 1536-bit data record (96 sixteen-bit words), because the record length is set only by when the caller raises `tail_i`.

When the record ends, the caller pulses `tail_i`. In generate mode (`mode_i` = 0) the unit then presents the 12 remainder bits on `ckw_bit_o`, one per valid cycle, for writing after the record. In check mode (`mode_i` = 1) it takes the next 12 valid bits as the checkword read back from the medium. It compares them with the regenerated remainder and raises a sticky error flag on any difference.

A controller states ACCUM, EMIT, VERIFY and DONE. The transitions are:
- ACCUM to EMIT on `tail_i` with `mode_i` = 0.
- ACCUM to VERIFY on `tail_i` with `mode_i` = 1.
- EMIT or VERIFY to DONE on the twelfth valid bit.
- Any state to ACCUM on `clr_i`.

Top module: `ckw_serial_unit`

## Requirements
- R1: After reset, `rem_o` is 0, and `err_o`, `done_o` and `ckw_vld_o` are all 0.
- R2: In ACCUM, a cycle with `vld_i` high and `tail_i` low updates the remainder, MSB first. The feedback bit f is `rem_o[11]` XOR `bit_i`. The next remainder is `rem_o` shifted left by one with a 0 entering bit 0, then XORed with 12'h80F (taps 11, 3, 2, 1, 0) when f is 1. After n bits, `rem_o` equals record·x^12 mod the generator.
- R3: A cycle with `vld_i` and `clr_i` both low leaves `rem_o` unchanged in every state.
- R4: `clr_i` sets the remainder to 0 and returns the unit to ACCUM from any state. It takes effect at the next clock edge, after which `done_o` is 0.
- R5: After `tail_i` with `mode_i` = 0, the next 12 cycles with `vld_i` high each drive `ckw_vld_o` = 1. In each of them `ckw_bit_o` shows the remainder MSB first, and the remainder shifts left with feedback disabled. After the twelfth bit the unit is in DONE (`done_o` = 1).
- R6: After `tail_i` with `mode_i` = 1, the next 12 valid bits are compared, in order, with the remainder MSB first. Any difference sets `err_o`. `ckw_vld_o` stays 0 throughout, and the unit enters DONE after the twelfth bit.
- R7: `err_o` stays set until `err_clr_i`. A cycle with `err_clr_i` high leaves `err_o` at 0, and the clear wins over a mismatch in the same cycle.
- R8: In DONE, valid bits and `tail_i` are ignored: `rem_o` and `done_o` hold until `clr_i`.
- R9: Feeding a record followed by its own 12-bit checkword through ACCUM leaves `rem_o` at 0.
- R10: Records of 24 and 1536 bits produce correct checkwords in both modes. A matching checkword leaves `err_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Start a new record: zero remainder, go to ACCUM |
| err_clr_i | input | 1 | Clear the sticky error flag |
| bit_i | input | 1 | Serial record or checkword bit |
| vld_i | input | 1 | Qualifies `bit_i` and paces checkword output |
| mode_i | input | 1 | 0 generate, 1 check; sampled with `tail_i` |
| tail_i | input | 1 | End of record, start checkword phase |
| ckw_bit_o | output | 1 | Checkword bit being emitted |
| ckw_vld_o | output | 1 | `ckw_bit_o` is valid |
| rem_o | output | 12 | Current remainder |
| err_o | output | 1 | Sticky checkword mismatch flag |
| done_o | output | 1 | Checkword phase complete |

## Verification
The bench builds the unit with its default 12-bit width and the fixed generator, so every value it checks is the real checkword. With these values, short 10-bit records become cheap enough to sweep every one of their 1024 patterns. Each pattern is run through generate mode, then check mode with the correct checkword, and a subset again with a single flipped checkword bit. Targeted runs then cover the 24-bit address length and the full 1536-bit record. Further runs cover clears mid-record and in DONE, idle gaps, and the sticky error flag.

// File: rtl/ckw_pkg.sv
package ckw_pkg;
    typedef enum logic [1:0] {
        ST_ACCUM  = 2'd0,
        ST_EMIT   = 2'd1,
        ST_VERIFY = 2'd2,
        ST_DONE   = 2'd3
    } ckw_state_e;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } ckw_mode_e;
endpackage

// File: rtl/ckw_divider.sv
module ckw_divider #(
    parameter int             W    = 12,
    parameter logic [W-1:0]   POLY = 12'h80F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         feed,
    input  logic         din,
    output logic [W-1:0] rem
);
    logic         fb;
    logic [W-1:0] nxt;

    // feedback only while dividing; a plain shift otherwise
    assign fb = feed & (rem[W-1] ^ din);

    generate
        for (genvar i = 0; i < W; i++) begin : g_tap
            if (i == 0) begin : g_lsb
                if (POLY[0]) begin : g_fb
                    assign nxt[0] = fb;
                end else begin : g_nofb
                    assign nxt[0] = 1'b0;
                end
            end else begin : g_up
                if (POLY[i]) begin : g_fb
                    assign nxt[i] = rem[i-1] ^ fb;
                end else begin : g_nofb
                    assign nxt[i] = rem[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rem <= '0;
        else if (clr)
            rem <= '0;
        else if (step)
            rem <= nxt;
    end
endmodule

// File: rtl/ckw_fsm.sv
module ckw_fsm
    import ckw_pkg::*;
#(
    parameter int W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic vld,
    input  logic tail,
    input  logic mode,
    output logic step,
    output logic feed,
    output logic emit,
    output logic verify,
    output logic done
);
    localparam int CW = $clog2(W);

    ckw_state_e    state, state_nxt;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_ACCUM;
        else
            state <= state_nxt;
    end

    // checkword bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || state == ST_ACCUM)
            cnt <= '0;
        else if ((state == ST_EMIT || state == ST_VERIFY) && vld)
            cnt <= cnt + CW'(1);
    end

    // transitions
    always_comb begin
        state_nxt = state;
        if (clr) begin
            state_nxt = ST_ACCUM;
        end else begin
            unique case (state)
                ST_ACCUM:  if (tail) state_nxt = (ckw_mode_e'(mode) == MODE_CHK) ? ST_VERIFY : ST_EMIT;
                ST_EMIT:   if (vld && last) state_nxt = ST_DONE;
                ST_VERIFY: if (vld && last) state_nxt = ST_DONE;
                ST_DONE:   state_nxt = ST_DONE;
            endcase
        end
    end

    // outputs
    always_comb begin
        step   = 1'b0;
        feed   = 1'b0;
        emit   = 1'b0;
        verify = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_ACCUM: begin
                feed = 1'b1;
                step = vld && !tail && !clr;
            end
            ST_EMIT: begin
                step = vld && !clr;
                emit = vld && !clr;
            end
            ST_VERIFY: begin
                step   = vld && !clr;
                verify = vld && !clr;
            end
            ST_DONE: done = 1'b1;
        endcase
    end
endmodule

// File: rtl/ckw_serial_unit.sv
module ckw_serial_unit #(
    parameter int           W    = 12,
    parameter logic [W-1:0] POLY = 12'h80F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         err_clr_i,
    input  logic         bit_i,
    input  logic         vld_i,
    input  logic         mode_i,
    input  logic         tail_i,
    output logic         ckw_bit_o,
    output logic         ckw_vld_o,
    output logic [W-1:0] rem_o,
    output logic         err_o,
    output logic         done_o
);
    logic step, feed, emit, verify, mismatch;

    ckw_fsm #(.W(W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_i),
        .vld    (vld_i),
        .tail   (tail_i),
        .mode   (mode_i),
        .step   (step),
        .feed   (feed),
        .emit   (emit),
        .verify (verify),
        .done   (done_o)
    );

    ckw_divider #(.W(W), .POLY(POLY)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_i),
        .step  (step),
        .feed  (feed),
        .din   (bit_i),
        .rem   (rem_o)
    );

    assign mismatch  = verify && (bit_i != rem_o[W-1]);
    assign ckw_vld_o = emit;
    assign ckw_bit_o = emit & rem_o[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_o <= 1'b0;
        else if (err_clr_i)
            err_o <= 1'b0;
        else if (mismatch)
            err_o <= 1'b1;
    end
endmodule

// File: rtl/ckw_serial_unit_chk.sv
module ckw_serial_unit_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_i,
    input logic         err_clr_i,
    input logic         vld_i,
    input logic         ckw_vld_o,
    input logic [W-1:0] rem_o,
    input logic         err_o,
    input logic         done_o
);
    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (rem_o == '0) && !done_o);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && !clr_i) |=> $stable(rem_o));

    // R5
    emit_plain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ckw_vld_o && !clr_i) |=> rem_o == {$past(rem_o[W-2:0]), 1'b0});

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr_i) |=> err_o);

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_i |=> !err_o);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> done_o && $stable(rem_o));
endmodule

bind ckw_serial_unit ckw_serial_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .err_clr_i (err_clr_i),
    .vld_i     (vld_i),
    .ckw_vld_o (ckw_vld_o),
    .rem_o     (rem_o),
    .err_o     (err_o),
    .done_o    (done_o)
);

// File: tb/sim_ckw_serial_unit.sv
`timescale 1ns/1ps
module sim_ckw_serial_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0, err_clr_i = 1'b0, bit_i = 1'b0, vld_i = 1'b0;
    logic        mode_i = 1'b0, tail_i = 1'b0;
    logic        ckw_bit_o, ckw_vld_o, err_o, done_o;
    logic [11:0] rem_o;

    int          checks = 0;
    int          errors = 0;
    logic [11:0] mrem = '0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    ckw_serial_unit u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .err_clr_i(err_clr_i),
        .bit_i(bit_i), .vld_i(vld_i), .mode_i(mode_i), .tail_i(tail_i),
        .ckw_bit_o(ckw_bit_o), .ckw_vld_o(ckw_vld_o), .rem_o(rem_o),
        .err_o(err_o), .done_o(done_o)
    );

    function automatic logic [11:0] mstep(input logic [11:0] r, input logic b);
        logic f;
        f = r[11] ^ b;
        mstep = {r[10:0], 1'b0} ^ (f ? 12'h80F : 12'h000);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        bit_i = b; vld_i = 1'b1;
        tick();
        vld_i = 1'b0;
        mrem = mstep(mrem, b);
    endtask

    task automatic clear();
        clr_i = 1'b1;
        tick();
        clr_i = 1'b0;
        mrem = '0;
    endtask

    task automatic go_tail(input logic m);
        mode_i = m; tail_i = 1'b1;
        tick();
        tail_i = 1'b0;
    endtask

    task automatic emit_all(output int bad);
        bad = 0;
        for (int i = 11; i >= 0; i--) begin
            vld_i = 1'b1;
            #1;
            if (!ckw_vld_o || ckw_bit_o !== mrem[i]) bad++;
            tick();
            vld_i = 1'b0;
        end
    endtask

    task automatic verify_word(input logic [11:0] w, output int bad);
        bad = 0;
        for (int i = 11; i >= 0; i--) begin
            bit_i = w[i]; vld_i = 1'b1;
            #1;
            if (ckw_vld_o) bad++;
            tick();
            vld_i = 1'b0;
        end
    endtask

    function automatic logic pat(input int k);
        logic [10:0] kk;
        kk = k[10:0];
        pat = ^(kk & 11'h5A3) ^ kk[0];
    endfunction

    initial begin
        #(4 * 190000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int          bad;
        logic [11:0] ck, inj, snap;
        tick(); tick();
        // R1
        check(rem_o == 0 && !err_o && !done_o && !ckw_vld_o, "R1", {rem_o, err_o, done_o}, 0);
        rst_n = 1'b1;
        tick();

        // exhaustive sweep of 10-bit records
        for (int v = 0; v < 1024; v++) begin
            logic [9:0] d;
            d = v[9:0];
            clear();
            for (int k = 9; k >= 0; k--) send_bit(d[k]);
            ck = mrem;
            check(rem_o == ck, "R2", rem_o, ck);
            go_tail(1'b0);
            emit_all(bad);
            check(bad == 0 && done_o, "R5", bad, 0);

            clear();
            for (int k = 9; k >= 0; k--) send_bit(d[k]);
            inj = (v % 37 == 0) ? (12'h001 << (v % 12)) : 12'h000;
            go_tail(1'b1);
            verify_word(ck ^ inj, bad);
            check(err_o == (inj != 0) && bad == 0 && done_o, "R6", err_o, inj != 0);
            if (err_o) begin
                err_clr_i = 1'b1; tick(); err_clr_i = 1'b0;
                check(!err_o, "R7", err_o, 0);
            end

            if (v % 128 == 5) begin
                clear();
                for (int k = 9; k >= 0; k--) send_bit(d[k]);
                for (int k = 11; k >= 0; k--) send_bit(ck[k]);
                check(rem_o == 0, "R9", rem_o, 0);
            end
        end

        // R3 idle gaps mid-record
        clear();
        for (int k = 0; k < 5; k++) send_bit(pat(k));
        snap = mrem;
        tick(); tick(); tick();
        check(rem_o == snap, "R3", rem_o, snap);

        // R4 clear mid-record
        clear();
        check(rem_o == 0 && !done_o, "R4", rem_o, 0);

        // R8 inputs ignored in DONE, then R4 clear from DONE
        for (int k = 0; k < 7; k++) send_bit(pat(k + 3));
        go_tail(1'b0);
        emit_all(bad);
        bit_i = 1'b1; vld_i = 1'b1; tail_i = 1'b1;
        tick();
        vld_i = 1'b0; tail_i = 1'b0;
        check(done_o && rem_o == 0 && !ckw_vld_o, "R8", {done_o, rem_o}, 13'h1000);
        clear();
        check(!done_o && rem_o == 0, "R4", {done_o, rem_o}, 0);

        // R7 sticky across a good record; clear wins over mismatch
        for (int k = 0; k < 8; k++) send_bit(pat(k));
        go_tail(1'b1);
        verify_word(~mrem, bad);
        clear();
        for (int k = 0; k < 8; k++) send_bit(pat(k));
        go_tail(1'b1);
        verify_word(mrem, bad);
        check(err_o, "R7", err_o, 1);
        clear();
        send_bit(1'b1);
        go_tail(1'b1);
        err_clr_i = 1'b1; bit_i = ~mrem[11]; vld_i = 1'b1;
        tick();
        err_clr_i = 1'b0; vld_i = 1'b0;
        check(!err_o, "R7", err_o, 0);

        // R10 address-length and full data record
        clear();
        for (int k = 23; k >= 0; k--) send_bit(((24'hA5C3F0 >> k) & 1) != 0);
        ck = mrem;
        go_tail(1'b0);
        emit_all(bad);
        check(bad == 0 && done_o, "R10", bad, 0);
        clear();
        for (int k = 0; k < 1536; k++) send_bit(pat(k));
        ck = mrem;
        check(rem_o == ck, "R10", rem_o, ck);
        go_tail(1'b0);
        emit_all(bad);
        check(bad == 0, "R10", bad, 0);
        clear();
        for (int k = 0; k < 1536; k++) send_bit(pat(k));
        go_tail(1'b1);
        verify_word(ck, bad);
        check(!err_o && done_o, "R10", err_o, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule